// File: doc/BRIEF.md
# Serial Multiplexed Seven-Segment Display Controller

This block drives up to eight common-cathode seven-segment digits, each with a decimal point. It scans them one at a time without help from a host. The host writes a small register file through a three-wire serial port. Each 16-bit word carries a 4-bit register address and one byte of data, and the word is committed when the load line rises.

The registers hold:
- the pattern for each digit;
- a per-digit choice between raw segments and a hexadecimal-style character decoder;
- a 16-step brightness setting;
- the number of digits scanned;
- a shutdown switch;
- a lamp-test switch.

Brightness is applied as a duty cycle on the enabled digit line. The serial input also passes through a 16-stage shift path to a serial output, so several controllers can share one link in a chain.

The serial pins are sampled by the system clock. An edge on them is recognised when a sample differs from the one taken on the previous clock.

Top module: `seg7_scan_ctrl`

## Requirements
- R1: A word is shifted in most-significant bit first, one bit on each rising edge of `ser_clk`. When `ser_load` rises, bits 11:8 of the last 16 bits are taken as the register address and bits 7:0 as the data. Bits 15:12 have no effect.
- R2: `ser_dout` is a 16-stage delay of `ser_din` counted in `ser_clk` rising edges. The bit captured on edge n is presented on `ser_dout` from edge n+15 until edge n+16.
- R3: After reset the controller is in shutdown. Decoding is off for all digits, the scan limit is 0, the brightness is 0, test mode is off and all digit patterns are 0. In this state `seg` is 0 and `dig_n` is 8'hFF.
- R4: Addresses 0x1 to 0x8 hold the patterns of digits 0 to 7. In raw mode, data bit 0 drives segment A, bits 1 to 6 drive segments B to G, and bit 7 drives the decimal point. These segments map to `seg[0]` through `seg[7]`.
- R5: Bit i of address 0x9 selects decoding for digit i. A decoded digit takes its low nibble through the character table and its bit 7 to the decimal point:

  | Nibble | Character | `seg[6:0]` |
  |---|---|---|
  | 0x0 | 0 | 0x3F |
  | 0x1 | 1 | 0x06 |
  | 0x2 | 2 | 0x5B |
  | 0x3 | 3 | 0x4F |
  | 0x4 | 4 | 0x66 |
  | 0x5 | 5 | 0x6D |
  | 0x6 | 6 | 0x7D |
  | 0x7 | 7 | 0x07 |
  | 0x8 | 8 | 0x7F |
  | 0x9 | 9 | 0x6F |
  | 0xA | - | 0x40 |
  | 0xB | E | 0x79 |
  | 0xC | H | 0x76 |
  | 0xD | L | 0x38 |
  | 0xE | P | 0x73 |
  | 0xF | blank | 0x00 |

- R6: Bits 2:0 of address 0xB give the last digit scanned, L. Digits 0 to L are enabled in ascending order and then the scan wraps to digit 0. At most one bit of `dig_n` is low at any time, and never a bit above L.
- R7: Bits 3:0 of address 0xA give the brightness I. Each digit slot lasts 16*PHASE_CYCLES clocks, and the digit line is low for the first (I+1)*PHASE_CYCLES of them.
- R8: Bit 0 of address 0xC set to 0 selects shutdown, and set to 1 selects normal operation. In shutdown the scan stops, `seg` is 0 and `dig_n` is 8'hFF.
- R9: Bit 0 of address 0xF set to 1 selects test mode. All eight digits are then scanned at full duty with every segment on, whatever the shutdown bit, scan limit, brightness or digit data.
- R10: Writes to address 0x0, 0xD or 0xE leave the display unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_din | input | 1 | Serial data in |
| ser_load | input | 1 | Word commit strobe; a rising edge writes the register |
| seg | output | 8 | Segment drive, bit 0 = A through bit 6 = G, bit 7 = decimal point |
| dig_n | output | 8 | Active-low digit enables, bit i = digit i |
| ser_dout | output | 1 | Delayed serial data for the next controller in a chain |

## Verification
The assertions assume that the serial pins change in step with `clk`. Each level of `ser_clk` and `ser_load` must be held for at least one clock, so that every edge is seen once. A rise of `ser_load` must never fall in the same clock as a rise of `ser_clk`. The stimulus meets this by holding every serial level for two clocks. It also returns `ser_clk` low before it raises `ser_load`. Random register contents are mixed with directed sweeps over all sixteen decoder codes and the extreme scan and brightness settings. The display is measured over one complete scan frame, after it has had time to settle following each change of configuration.

// File: rtl/seg7_pkg.sv
// Shared constants and the character decoder for the seven-segment
// controller. Assumes segment order A..G in bits 0..6.
package seg7_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int WORD_W = 16;

    localparam logic [ADDR_W-1:0] ADR_NOP    = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_DECODE = 4'h9;
    localparam logic [ADDR_W-1:0] ADR_BRIGHT = 4'hA;
    localparam logic [ADDR_W-1:0] ADR_LIMIT  = 4'hB;
    localparam logic [ADDR_W-1:0] ADR_POWER  = 4'hC;
    localparam logic [ADDR_W-1:0] ADR_LAMP   = 4'hF;

    // Map a nibble to its character segments (A = bit 0).
    function automatic logic [6:0] char_segs(input logic [3:0] v);
        case (v)
            4'h0: char_segs = 7'h3F;
            4'h1: char_segs = 7'h06;
            4'h2: char_segs = 7'h5B;
            4'h3: char_segs = 7'h4F;
            4'h4: char_segs = 7'h66;
            4'h5: char_segs = 7'h6D;
            4'h6: char_segs = 7'h7D;
            4'h7: char_segs = 7'h07;
            4'h8: char_segs = 7'h7F;
            4'h9: char_segs = 7'h6F;
            4'hA: char_segs = 7'h40;
            4'hB: char_segs = 7'h79;
            4'hC: char_segs = 7'h76;
            4'hD: char_segs = 7'h38;
            4'hE: char_segs = 7'h73;
            default: char_segs = 7'h00;
        endcase
    endfunction

endpackage

// File: rtl/seg7_shift_in.sv
// Serial front end: samples the three serial pins with clk, shifts a
// 16-bit word on each rising ser_clk and issues a one-cycle write on
// each rising ser_load. Assumes the pins are synchronous to clk and
// each level lasts at least one clock.
module seg7_shift_in
    import seg7_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_load,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              ser_dout
);

    logic              sclk_q;
    logic              load_q;
    logic [WORD_W-1:0] shreg;
    logic              shift_evt;

    assign shift_evt = ser_clk && !sclk_q;

    // Edge history and word shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            load_q <= 1'b0;
            shreg  <= '0;
        end else begin
            sclk_q <= ser_clk;
            load_q <= ser_load;
            if (shift_evt) begin
                shreg <= {shreg[WORD_W-2:0], ser_din};
            end
        end
    end

    assign wr_en    = ser_load && !load_q;
    assign wr_addr  = shreg[DATA_W +: ADDR_W];
    assign wr_data  = shreg[DATA_W-1:0];
    assign ser_dout = shreg[WORD_W-1];

    // R1: the word is frozen between serial clock edges.
    p_word_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_evt |=> $stable(wr_addr) && $stable(wr_data));

endmodule

// File: rtl/seg7_regfile.sv
// Register file: digit patterns, decode select, brightness, scan limit,
// power and lamp-test bits. Writes come from the serial front end.
// Assumes NUM_DIGITS <= 8.
module seg7_regfile
    import seg7_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    parameter int IDX_W      = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_DIGITS-1:0][DATA_W-1:0]  digits,
    output logic [NUM_DIGITS-1:0]              decode_sel,
    output logic [3:0]                         bright,
    output logic [IDX_W-1:0]                   last_idx,
    output logic                               run_on,
    output logic                               lamp_on
);

    // One pattern register per digit, at address index+1.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                digits[g] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(g + 1)) begin
                digits[g] <= wr_data;
            end
        end
    end

    // Control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decode_sel <= '0;
            bright     <= '0;
            last_idx   <= '0;
            run_on     <= 1'b0;
            lamp_on    <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_DECODE: decode_sel <= wr_data[NUM_DIGITS-1:0];
                ADR_BRIGHT: bright     <= wr_data[3:0];
                ADR_LIMIT:  last_idx   <= wr_data[IDX_W-1:0];
                ADR_POWER:  run_on     <= wr_data[0];
                ADR_LAMP:   lamp_on    <= wr_data[0];
                default: ;
            endcase
        end
    end

    // R10: the no-op and unused addresses change no state.
    p_nop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == ADR_NOP || wr_addr == 4'hD || wr_addr == 4'hE)
        |=> $stable(digits) && $stable(decode_sel) && $stable(bright)
            && $stable(last_idx) && $stable(run_on) && $stable(lamp_on));

endmodule

// File: rtl/seg7_scanner.sv
// Scan engine: steps through digits 0..limit, splits each digit slot
// into 16 sub-phases of PHASE_CYCLES clocks for brightness, and forms
// the segment pattern with optional character decoding. Shutdown
// freezes the scan; lamp test overrides everything.
module seg7_scanner
    import seg7_pkg::*;
#(
    parameter int NUM_DIGITS   = 8,
    parameter int IDX_W        = 3,
    parameter int PHASE_CYCLES = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_DIGITS-1:0][DATA_W-1:0]  digits,
    input  logic [NUM_DIGITS-1:0]              decode_sel,
    input  logic [3:0]                         bright,
    input  logic [IDX_W-1:0]                   last_idx,
    input  logic                               run_on,
    input  logic                               lamp_on,
    output logic [DATA_W-1:0]                  seg,
    output logic [NUM_DIGITS-1:0]              dig_n
);

    localparam int PH_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;

    logic [PH_W-1:0]   ph;
    logic [3:0]        sub;
    logic [IDX_W-1:0]  idx;
    logic              active;
    logic [IDX_W-1:0]  eff_last;
    logic              lit;
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] pat;

    assign active   = run_on || lamp_on;
    assign eff_last = lamp_on ? IDX_W'(NUM_DIGITS - 1) : last_idx;

    // Phase, sub-phase and digit counters; frozen while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= '0;
            sub <= '0;
            idx <= '0;
        end else if (active) begin
            if (ph == PH_W'(PHASE_CYCLES - 1)) begin
                ph  <= '0;
                sub <= sub + 4'd1;
                if (sub == 4'hF) begin
                    idx <= (idx >= eff_last) ? '0 : idx + 1'b1;
                end
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    // Digit enable with brightness gating.
    always_comb begin
        lit   = active && (idx <= eff_last) && (lamp_on || sub <= bright);
        dig_n = ~(lit ? (NUM_DIGITS'(1) << idx) : '0);
    end

    // Segment pattern for the current digit.
    always_comb begin
        raw = digits[idx];
        pat = decode_sel[idx] ? {raw[7], char_segs(raw[3:0])} : raw;
        seg = lamp_on ? '1 : (active ? pat : '0);
    end

    // R6: never more than one digit enabled.
    p_single_digit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dig_n));

    // R6: the scan moves up by one or wraps to digit 0.
    p_scan_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != $past(idx)) |-> (idx == '0 || idx == $past(idx) + 1'b1));

    // R8: in shutdown the scan position holds.
    p_halt_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(idx) && $stable(sub));

    // R9: in lamp test a digit is always enabled.
    p_lamp_lit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_on |-> dig_n != '1);

endmodule

// File: rtl/seg7_scan_ctrl.sv
// Top of the serial seven-segment controller: serial front end,
// register file and scan engine. Assumes serial pins are synchronous
// to clk.
module seg7_scan_ctrl
    import seg7_pkg::*;
#(
    parameter int NUM_DIGITS   = 8,
    parameter int PHASE_CYCLES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk,
    input  logic                  ser_din,
    input  logic                  ser_load,
    output logic [DATA_W-1:0]     seg,
    output logic [NUM_DIGITS-1:0] dig_n,
    output logic                  ser_dout
);

    localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

    logic                              wr_en;
    logic [ADDR_W-1:0]                 wr_addr;
    logic [DATA_W-1:0]                 wr_data;
    logic [NUM_DIGITS-1:0][DATA_W-1:0] digits;
    logic [NUM_DIGITS-1:0]             decode_sel;
    logic [3:0]                        bright;
    logic [IDX_W-1:0]                  last_idx;
    logic                              run_on;
    logic                              lamp_on;

    seg7_shift_in u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_din  (ser_din),
        .ser_load (ser_load),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ser_dout (ser_dout)
    );

    seg7_regfile #(
        .NUM_DIGITS (NUM_DIGITS),
        .IDX_W      (IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .digits     (digits),
        .decode_sel (decode_sel),
        .bright     (bright),
        .last_idx   (last_idx),
        .run_on     (run_on),
        .lamp_on    (lamp_on)
    );

    seg7_scanner #(
        .NUM_DIGITS   (NUM_DIGITS),
        .IDX_W        (IDX_W),
        .PHASE_CYCLES (PHASE_CYCLES)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .digits     (digits),
        .decode_sel (decode_sel),
        .bright     (bright),
        .last_idx   (last_idx),
        .run_on     (run_on),
        .lamp_on    (lamp_on),
        .seg        (seg),
        .dig_n      (dig_n)
    );

    // R3: reset leaves the display dark until a register is written.
    p_reset_dark_r3: assert property (@(posedge clk)
        !rst_n |=> (seg == '0 && dig_n == '1));

endmodule

// File: tb/seg7_scan_ctrl_test.sv
`timescale 1ns/1ps
module seg7_scan_ctrl_test;

    localparam int P = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_load = 1'b0;
    logic [7:0] seg;
    logic [7:0] dig_n;
    logic       ser_dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_dig [8];
    logic [7:0] m_dec;
    logic [3:0] m_int;
    logic [2:0] m_lim;
    logic       m_run;
    logic       m_test;

    always #2.5 clk = ~clk;

    seg7_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_load(ser_load), .seg(seg), .dig_n(dig_n), .ser_dout(ser_dout)
    );

    function automatic logic [6:0] tb_char(input logic [3:0] v);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D,
                               7'h7D, 7'h07, 7'h7F, 7'h6F, 7'h40, 7'h79,
                               7'h76, 7'h38, 7'h73, 7'h00};
        return t[v];
    endfunction

    function automatic logic [7:0] exp_seg(input int i);
        if (m_test) return 8'hFF;
        if (m_dec[i]) return {m_dig[i][7], tb_char(m_dig[i][3:0])};
        return m_dig[i];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            ser_din = w[i];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic pulse_load();
        ser_load = 1'b1;
        repeat (2) @(negedge clk);
        ser_load = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        if (a >= 4'h1 && a <= 4'h8) m_dig[a - 1] = d;
        else if (a == 4'h9) m_dec = d;
        else if (a == 4'hA) m_int = d[3:0];
        else if (a == 4'hB) m_lim = d[2:0];
        else if (a == 4'hC) m_run = d[0];
        else if (a == 4'hF) m_test = d[0];
    endtask

    // R1: random upper nibble on every word; it must have no effect.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic [3:0] junk;
        junk = 4'($urandom);
        send_word({junk, a, d});
        pulse_load();
        model_write(a, d);
    endtask

    // Observe one full frame after settling and compare with the model.
    task automatic check_display(input string tag);
        int  elim, win, lowcnt, bad_one, bad_lim, bad_seg, bad_shut, bad_gap;
        int  a_seg, e_seg, exp_cnt;
        bit  active;
        logic [7:0] seen, on;
        active = m_run || m_test;
        elim   = m_test ? 7 : int'(m_lim);
        repeat (300) @(negedge clk);
        win = active ? (elim + 1) * 16 * P : 64;
        lowcnt = 0; bad_one = 0; bad_lim = 0; bad_seg = 0; bad_shut = 0;
        bad_gap = 0; seen = '0; a_seg = 0; e_seg = 0;
        for (int c = 0; c < win; c++) begin
            @(negedge clk);
            if (!active) begin
                if (seg != 8'h00 || dig_n != 8'hFF) begin
                    bad_shut++; a_seg = {seg, dig_n}; e_seg = 16'h00FF;
                end
            end else if (dig_n != 8'hFF) begin
                on = ~dig_n;
                if ($countones(on) != 1) bad_one++;
                else begin
                    int idx = 0;
                    for (int k = 0; k < 8; k++) if (on[k]) idx = k;
                    if (idx > elim) bad_lim++;
                    if (seg != exp_seg(idx)) begin
                        bad_seg++; a_seg = seg; e_seg = exp_seg(idx);
                    end
                end
                lowcnt++;
                seen |= on;
            end else if (m_test) begin
                bad_gap++;
            end
        end
        if (!active) begin
            chk(bad_shut == 0, {tag, " R8"}, "shutdown outputs {seg,dig_n}", a_seg, e_seg);
        end else begin
            exp_cnt = (elim + 1) * P * (m_test ? 16 : int'(m_int) + 1);
            chk(bad_one == 0 && bad_lim == 0, {tag, " R6"}, "digits beyond limit or several on",
                bad_one + bad_lim, 0);
            chk(seen == 8'((16'h1 << (elim + 1)) - 1), {tag, " R6"}, "digits visited",
                seen, 8'((16'h1 << (elim + 1)) - 1));
            chk(bad_seg == 0, m_test ? {tag, " R9"} : {tag, " R4 R5"}, "segment pattern",
                a_seg, e_seg);
            chk(lowcnt == exp_cnt && bad_gap == 0, m_test ? {tag, " R9"} : {tag, " R7"},
                "lit cycles per frame", lowcnt, exp_cnt);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] stream;
        int bad, a_bit, e_bit;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_dig[i] = '0;
        m_dec = '0; m_int = '0; m_lim = '0; m_run = 1'b0; m_test = 1'b0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state is dark.
        bad = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (seg != 8'h00 || dig_n != 8'hFF) bad++;
        end
        chk(bad == 0, "R3", "reset outputs {seg,dig_n}", {seg, dig_n}, 16'h00FF);

        // R8: data written while shut down stays dark.
        wr(4'h1, 8'hA5);
        wr(4'h2, 8'h3C);
        check_display("shutdown");

        // R3: leave shutdown; only digit 0, raw, brightness 0 (1/16 duty).
        wr(4'hC, 8'h01);
        bad = 0;
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            if (dig_n != 8'hFF) begin
                bad++;
                if (dig_n != 8'hFE || seg != 8'hA5) bad += 1000;
            end
        end
        chk(bad == 2 * 2 * P / 2, "R3", "default lit cycles/pattern", bad, 2 * 2 * P / 2);
        check_display("R3 defaults");

        // Random configurations.
        for (int it = 0; it < 8; it++) begin
            for (int d = 1; d <= 8; d++) wr(4'(d), 8'($urandom));
            wr(4'h9, 8'($urandom));
            wr(4'hA, 8'($urandom));
            wr(4'hB, 8'($urandom));
            check_display("R1 random");
        end

        // R5: every decoder code, full scan, extreme brightness values.
        wr(4'h9, 8'hFF);
        wr(4'hB, 8'h07);
        for (int half = 0; half < 2; half++) begin
            for (int d = 0; d < 8; d++)
                wr(4'(d + 1), {1'($urandom), 3'($urandom), 4'(d + 8 * half)});
            wr(4'hA, half ? 8'h0F : 8'h00);
            check_display("R5 codes");
        end

        // R6: scan limit 0 and a middle value.
        wr(4'hB, 8'h00);
        check_display("R6 limit0");
        wr(4'hB, 8'hF3);
        check_display("R6 limit3");

        // R10: no-op and unused addresses leave the display as it is.
        wr(4'h0, 8'hFF);
        wr(4'hD, 8'h00);
        wr(4'hE, 8'h55);
        check_display("R10 noop");

        // R9: test mode overrides shutdown, limit and brightness.
        wr(4'hC, 8'h00);
        wr(4'hF, 8'h01);
        check_display("R9 test");
        wr(4'hF, 8'h00);
        check_display("R8 after test");
        wr(4'hC, 8'h01);

        // R2: delayed serial output across two words.
        stream = {16'h0B6D, 16'h04C3};
        bad = 0; a_bit = 0; e_bit = 0;
        for (int n = 1; n <= 32; n++) begin
            ser_din = stream[32 - n];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            @(negedge clk);
            if (n >= 16 && ser_dout !== stream[47 - n]) begin
                bad++; a_bit = ser_dout; e_bit = stream[47 - n];
            end
            @(negedge clk);
            ser_clk = 1'b0;
        end
        chk(bad == 0, "R2", "ser_dout delay", a_bit, e_bit);
        pulse_load();
        model_write(4'h4, 8'hC3);
        check_display("R2 chained write");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule